// File: doc/BRIEF.md
# Precision-Switchable Systolic Matrix Engine

This block is a two-dimensional grid of multiply-accumulate cells that computes the product of a stream of activation vectors and a stream of weight vectors for one quantized network layer at a time. Each cell keeps its own output value in place. Activations travel left to right along the rows. Weights travel top to bottom along the columns. Aligned input vectors are accepted one beat per cycle. The block applies the staggering internally, one cycle per row and per column, so that every activation and weight pair meets at the cell it belongs to. When the layer's beats are complete and the grid has flushed, the accumulated results move down the columns and leave the bottom edge one row per cycle.

Before each layer, a configuration word sets two things: an operand precision and a beat count. Every cell uses the same precision code. Each cell builds its multiplier from 2-bit by 2-bit digit products. For each code it groups those digit products differently, so an 8-bit lane carries one 8-bit operand, two packed 4-bit operands or four packed 2-bit operands. The lane widths, the result width and the handshake stay the same for every precision. A new configuration is refused while a layer is still computing or draining. A one-cycle pulse marks the end of each layer.

Top module: `msa_array`

## Requirements
- R1: The precision code selects the per-lane product of unsigned operands a and b. Code 00 is a*b on all 8 bits. Code 01 is a[3:0]*b[3:0] + a[7:4]*b[7:4]. Code 10 is the sum of a[2i+1:2i]*b[2i+1:2i] for i = 0..3. Code 11 behaves exactly like code 00.
- R2: Result element (r,c) equals the sum, over all accepted beats, of the R1 product of activation lane r (act_in[8r+7:8r]) and weight lane c (wgt_in[8c+7:8c]) from the same beat. Beats may be separated by idle cycles.
- R3: Each result field is 16+LEN_W bits wide and holds the largest possible sum without overflow: all operands 0xFF, code 00, 2^LEN_W-1 beats.
- R4: A configuration is taken when cfg_valid is high and busy is low. busy is high in the next cycle. All results of the new layer start from zero.
- R5: cfg_valid while busy is high is ignored. The running layer keeps its precision and beat count.
- R6: Exactly cfg_len beats with in_valid high are accumulated after a configuration is taken. in_valid while idle, and in_valid after the cfg_len-th beat, have no effect. A cfg_len of 0 gives all-zero results.
- R7: Results leave on res_row during ROWS consecutive cycles with res_valid high. Row ROWS-1 comes first, then the rows in decreasing order. Column c is res_row[(c+1)*ACC_W-1:c*ACC_W]. busy stays high throughout.
- R8: layer_done is high for exactly one cycle, the cycle right after the last res_valid cycle. busy is low in that cycle.
- R9: After reset, busy, res_valid and layer_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration request |
| cfg_prec | input | 2 | Precision code for the layer |
| cfg_len | input | LEN_W | Number of beats in the layer |
| busy | output | 1 | Layer in progress; configuration refused |
| in_valid | input | 1 | Input beat present |
| act_in | input | ROWS*8 | Activation vector, one lane per row |
| wgt_in | input | COLS*8 | Weight vector, one lane per column |
| res_valid | output | 1 | res_row carries a result row |
| res_row | output | COLS*ACC_W | One row of results |
| layer_done | output | 1 | End-of-layer pulse |

## Verification
The hardest situation to reach is a configuration request or an extra input beat that arrives while a layer is already running. It must leave no trace in the results. The stimulus sends a request with a different precision in the same cycle as the first beat, and keeps in_valid high for several cycles past the beat count. It also sends beats of all-ones data before the layer is configured. The results are then compared with values computed for the original configuration only. Packed operand values are chosen so that the 8-bit, 4-bit and 2-bit groupings give different sums, which makes any leak of the wrong precision or of a stray beat visible.

// File: rtl/msa_pkg.sv
// Shared widths and codes for the precision-switchable systolic engine.
// Assumes 8-bit operand lanes built from 2-bit digits.
package msa_pkg;
    localparam int OPW   = 8;
    localparam int PRODW = 2 * OPW;
    localparam int NDIG  = OPW / 2;

    typedef enum logic [1:0] {
        PREC_W8  = 2'b00,
        PREC_W4  = 2'b01,
        PREC_W2  = 2'b10,
        PREC_RSV = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FLUSH,
        ST_DRAIN
    } st_e;
endpackage

// File: rtl/msa_mult.sv
// Regroupable lane multiplier: forms every 2x2-bit digit product of a and b,
// then sums one subset of them per precision code. Purely combinational.
// Assumes unsigned operands; code 11 is treated as full 8-bit.
module msa_mult
    import msa_pkg::*;
(
    input  logic [1:0]       prec,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [PRODW-1:0] p
);
    localparam int HALF = NDIG / 2;

    logic [3:0]       dig [NDIG][NDIG];
    logic [PRODW-1:0] s8, s4, s2;

    for (genvar i = 0; i < NDIG; i++) begin : g_i
        for (genvar j = 0; j < NDIG; j++) begin : g_j
            assign dig[i][j] = a[2*i +: 2] * b[2*j +: 2];
        end
    end

    // Sum the digit products for each of the three groupings.
    always_comb begin
        s8 = '0;
        s4 = '0;
        s2 = '0;
        for (int i = 0; i < NDIG; i++) begin
            for (int j = 0; j < NDIG; j++) begin
                s8 = s8 + (PRODW'(dig[i][j]) << (2 * (i + j)));
                if ((i < HALF) && (j < HALF))
                    s4 = s4 + (PRODW'(dig[i][j]) << (2 * (i + j)));
                else if ((i >= HALF) && (j >= HALF))
                    s4 = s4 + (PRODW'(dig[i][j]) << (2 * (i + j - 2 * HALF)));
                if (i == j)
                    s2 = s2 + PRODW'(dig[i][j]);
            end
        end
    end

    // Pick the grouping named by the layer's precision code.
    always_comb begin
        case (prec)
            PREC_W4: p = s4;
            PREC_W2: p = s2;
            default: p = s8;
        endcase
    end
endmodule

// File: rtl/msa_skew.sv
// Fixed delay line of DEPTH register stages, used to stagger one input lane.
// Assumes DEPTH >= 1; lanes without delay are wired directly by the parent.
module msa_skew #(
    parameter int W     = 9,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    // Move the lane one stage further on every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/msa_pe.sv
// Output-stationary cell: multiplies the operands that meet here and adds the
// product into a local sum. In drain mode it loads the sum of the cell above.
// Assumes clear, drain and valid never coincide.
module msa_pe
    import msa_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic [1:0]       prec,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    input  logic             v,
    input  logic [ACC_W-1:0] acc_up,
    output logic [ACC_W-1:0] acc
);
    logic [PRODW-1:0] prod;

    msa_mult u_mult (
        .prec (prec),
        .a    (a),
        .b    (b),
        .p    (prod)
    );

    // Clear, drain downwards, or accumulate a valid product.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clr)   acc <= '0;
        else if (shift) acc <= acc_up;
        else if (v)     acc <= acc + ACC_W'(prod);
    end
endmodule

// File: rtl/msa_ctrl.sv
// Layer sequencer: takes a configuration while idle, counts the input beats,
// waits for the grid to flush, then drains ROWS rows and pulses done.
// Assumes the flush wait of ROWS+COLS cycles covers the deepest cell.
module msa_ctrl
    import msa_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_prec,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    output logic             busy,
    output logic             accept,
    output logic             clr,
    output logic             shift,
    output logic             res_valid,
    output logic             layer_done,
    output logic [1:0]       prec_q
);
    localparam int FLUSH_N = ROWS + COLS;
    localparam int FL_W    = $clog2(FLUSH_N + 1);
    localparam int DR_W    = $clog2(ROWS + 1);

    st_e              st;
    logic [LEN_W-1:0] cnt, len_q;
    logic [FL_W-1:0]  fl;
    logic [DR_W-1:0]  dr;

    assign busy      = (st != ST_IDLE);
    assign clr       = (st == ST_IDLE) && cfg_valid;
    assign accept    = (st == ST_RUN) && in_valid && (cnt != len_q);
    assign shift     = (st == ST_DRAIN);
    assign res_valid = shift;

    // Advance the layer through run, flush and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            len_q      <= '0;
            fl         <= '0;
            dr         <= '0;
            prec_q     <= '0;
            layer_done <= 1'b0;
        end else begin
            layer_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cfg_valid) begin
                        prec_q <= cfg_prec;
                        len_q  <= cfg_len;
                        cnt    <= '0;
                        st     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt == len_q) begin
                        fl <= '0;
                        st <= ST_FLUSH;
                    end else if (in_valid) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    if (fl == FL_W'(FLUSH_N - 1)) begin
                        dr <= '0;
                        st <= ST_DRAIN;
                    end else begin
                        fl <= fl + 1'b1;
                    end
                end
                default: begin
                    if (dr == DR_W'(ROWS - 1)) begin
                        st         <= ST_IDLE;
                        layer_done <= 1'b1;
                    end else begin
                        dr <= dr + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/msa_array.sv
// Top of the systolic engine: staggers aligned input vectors, forwards
// operands right and down through a ROWS x COLS grid of cells, and drains the
// results out of the bottom row. Assumes one configuration per layer.
module msa_array
    import msa_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LEN_W = 8,
    localparam int ACC_W = PRODW + LEN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic [1:0]            cfg_prec,
    input  logic [LEN_W-1:0]      cfg_len,
    output logic                  busy,
    input  logic                  in_valid,
    input  logic [ROWS*OPW-1:0]   act_in,
    input  logic [COLS*OPW-1:0]   wgt_in,
    output logic                  res_valid,
    output logic [COLS*ACC_W-1:0] res_row,
    output logic                  layer_done
);
    logic             accept, clr, shift;
    logic [1:0]       prec_q;
    logic [OPW-1:0]   a_h [ROWS][COLS];
    logic             v_h [ROWS][COLS];
    logic [OPW-1:0]   b_v [ROWS][COLS];
    logic [ACC_W-1:0] acc [ROWS][COLS];

    msa_ctrl #(.ROWS(ROWS), .COLS(COLS), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_prec   (cfg_prec),
        .cfg_len    (cfg_len),
        .in_valid   (in_valid),
        .busy       (busy),
        .accept     (accept),
        .clr        (clr),
        .shift      (shift),
        .res_valid  (res_valid),
        .layer_done (layer_done),
        .prec_q     (prec_q)
    );

    // Row r activations and their valid flag are delayed r cycles.
    for (genvar r = 0; r < ROWS; r++) begin : g_rskew
        if (r == 0) begin : g_direct
            assign a_h[0][0] = act_in[0 +: OPW];
            assign v_h[0][0] = accept;
        end else begin : g_delay
            logic [OPW:0] sk;
            msa_skew #(.W(OPW + 1), .DEPTH(r)) u_sk (
                .clk   (clk),
                .rst_n (rst_n),
                .din   ({accept, act_in[r*OPW +: OPW]}),
                .dout  (sk)
            );
            assign a_h[r][0] = sk[OPW-1:0];
            assign v_h[r][0] = sk[OPW];
        end
    end

    // Column c weights are delayed c cycles.
    for (genvar c = 0; c < COLS; c++) begin : g_cskew
        if (c == 0) begin : g_direct
            assign b_v[0][0] = wgt_in[0 +: OPW];
        end else begin : g_delay
            msa_skew #(.W(OPW), .DEPTH(c)) u_sk (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (wgt_in[c*OPW +: OPW]),
                .dout  (b_v[0][c])
            );
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [ACC_W-1:0] up;

            if (r == 0) begin : g_top
                assign up = '0;
            end else begin : g_inner
                assign up = acc[r-1][c];
            end

            msa_pe #(.ACC_W(ACC_W)) u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr),
                .shift  (shift),
                .prec   (prec_q),
                .a      (a_h[r][c]),
                .b      (b_v[r][c]),
                .v      (v_h[r][c]),
                .acc_up (up),
                .acc    (acc[r][c])
            );

            if (c < COLS - 1) begin : g_fwd_a
                logic [OPW-1:0] a_q;
                logic           v_q;
                // Pass the activation and its valid flag one cell right.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        a_q <= '0;
                        v_q <= 1'b0;
                    end else begin
                        a_q <= a_h[r][c];
                        v_q <= v_h[r][c];
                    end
                end
                assign a_h[r][c+1] = a_q;
                assign v_h[r][c+1] = v_q;
            end

            if (r < ROWS - 1) begin : g_fwd_b
                logic [OPW-1:0] b_q;
                // Pass the weight one cell down.
                always_ff @(posedge clk) begin
                    if (!rst_n) b_q <= '0;
                    else        b_q <= b_v[r][c];
                end
                assign b_v[r+1][c] = b_q;
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_out
        assign res_row[c*ACC_W +: ACC_W] = acc[ROWS-1][c];
    end
endmodule

// File: rtl/msa_array_chk.sv
// Protocol checker for msa_array: configuration hold, drain framing and the
// end-of-layer pulse. Attached to every msa_array instance by bind.
module msa_array_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_valid,
    input logic       busy,
    input logic       res_valid,
    input logic       layer_done,
    input logic [1:0] prec_q
);
    AST_CFG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !busy) |=> busy);                                 // R4
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prec_q));                                      // R5
    AST_DRAIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);                                            // R7
    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(res_valid) |-> layer_done);                               // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        layer_done |=> !layer_done);                                    // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        layer_done |-> (!busy && !res_valid));                          // R8
endmodule

bind msa_array msa_array_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .busy       (busy),
    .res_valid  (res_valid),
    .layer_done (layer_done),
    .prec_q     (prec_q)
);

// File: tb/tb_msa_array.sv
module tb_msa_array;
    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int LEN_W = 8;
    localparam int OPW   = 8;
    localparam int ACC_W = 2 * OPW + LEN_W;

    typedef struct packed {
        logic [1:0] prec;
        logic [7:0] len;
        logic [7:0] seed;
        logic       gap;
    } vec_t;

    // Table of layers: precision, beat count, operand seed, idle gaps.
    localparam vec_t VEC [8] = '{
        '{2'b00, 8'd8,  8'd1, 1'b0},
        '{2'b01, 8'd8,  8'd2, 1'b0},
        '{2'b10, 8'd8,  8'd3, 1'b0},
        '{2'b11, 8'd6,  8'd4, 1'b0},
        '{2'b00, 8'd5,  8'd5, 1'b1},
        '{2'b01, 8'd12, 8'd6, 1'b1},
        '{2'b10, 8'd1,  8'd7, 1'b0},
        '{2'b00, 8'd16, 8'd8, 1'b0}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  cfg_valid = 1'b0;
    logic [1:0]            cfg_prec = '0;
    logic [LEN_W-1:0]      cfg_len = '0;
    logic                  busy;
    logic                  in_valid = 1'b0;
    logic [ROWS*OPW-1:0]   act_in = '0;
    logic [COLS*OPW-1:0]   wgt_in = '0;
    logic                  res_valid;
    logic [COLS*ACC_W-1:0] res_row;
    logic                  layer_done;

    int errors = 0;
    int checks = 0;
    int exp_acc [ROWS][COLS];

    always #10 clk = ~clk;

    msa_array #(.ROWS(ROWS), .COLS(COLS), .LEN_W(LEN_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_prec   (cfg_prec),
        .cfg_len    (cfg_len),
        .busy       (busy),
        .in_valid   (in_valid),
        .act_in     (act_in),
        .wgt_in     (wgt_in),
        .res_valid  (res_valid),
        .res_row    (res_row),
        .layer_done (layer_done)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int mulp(input logic [1:0] p, input int a, input int b);
        int s;
        case (p)
            2'b01: return (a & 15) * (b & 15) + ((a >> 4) & 15) * ((b >> 4) & 15);
            2'b10: begin
                s = 0;
                for (int i = 0; i < 4; i++) s += ((a >> (2*i)) & 3) * ((b >> (2*i)) & 3);
                return s;
            end
            default: return a * b;
        endcase
    endfunction

    function automatic int opa(input int seed, input int k, input int r);
        if (seed == 255) return 255;
        return (seed * 37 + k * 13 + r * 71 + 5) & 255;
    endfunction

    function automatic int opb(input int seed, input int k, input int c);
        if (seed == 255) return 255;
        return (seed * 91 + k * 29 + c * 53 + 11) & 255;
    endfunction

    // One layer: configure, stream beats, collect the drained rows.
    task automatic run_layer(input logic [1:0] p, input int len, input int seed,
                             input bit gap, input bit inject, input int extra,
                             input string tag);
        int t;
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_prec  = p;
        cfg_len   = LEN_W'(len);
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(busy == 1'b1, {"R4 busy after cfg ", tag}, int'(busy), 1);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                exp_acc[r][c] = 0;
                for (int k = 0; k < len; k++)
                    exp_acc[r][c] += mulp(p, opa(seed, k, r), opb(seed, k, c));
            end
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            for (int r = 0; r < ROWS; r++) act_in[r*OPW +: OPW] = OPW'(opa(seed, k, r));
            for (int c = 0; c < COLS; c++) wgt_in[c*OPW +: OPW] = OPW'(opb(seed, k, c));
            if (inject && k == 0) begin
                cfg_valid = 1'b1;
                cfg_prec  = p ^ 2'b01;
                cfg_len   = LEN_W'(3);
            end
            @(negedge clk);
            cfg_valid = 1'b0;
            if (gap) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        for (int e = 0; e < extra; e++) begin
            in_valid = 1'b1;
            act_in   = '1;
            wgt_in   = '1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        t = 0;
        while (!res_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        for (int d = 0; d < ROWS; d++) begin
            chk(res_valid == 1'b1, {"R7 drain valid ", tag}, int'(res_valid), 1);
            chk(busy == 1'b1, {"R7 busy in drain ", tag}, int'(busy), 1);
            for (int c = 0; c < COLS; c++)
                chk(int'(res_row[c*ACC_W +: ACC_W]) == exp_acc[ROWS-1-d][c],
                    {"R2 R1 result ", tag}, int'(res_row[c*ACC_W +: ACC_W]),
                    exp_acc[ROWS-1-d][c]);
            @(negedge clk);
        end
        chk(layer_done == 1'b1, {"R8 done pulse ", tag}, int'(layer_done), 1);
        chk(busy == 1'b0, {"R8 idle at done ", tag}, int'(busy), 0);
        chk(res_valid == 1'b0, {"R7 drain length ", tag}, int'(res_valid), 0);
        @(negedge clk);
        chk(layer_done == 1'b0, {"R8 done one cycle ", tag}, int'(layer_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(res_valid == 1'b0, "R9 reset res_valid", int'(res_valid), 0);
        chk(layer_done == 1'b0, "R9 reset layer_done", int'(layer_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after reset", int'(busy), 0);

        // Table walk over precisions, lengths and gapped streams (R1, R2, R4).
        foreach (VEC[i])
            run_layer(VEC[i].prec, int'(VEC[i].len), int'(VEC[i].seed),
                      VEC[i].gap, 1'b0, 0, "table");

        // R6: beats while idle are ignored.
        in_valid = 1'b1;
        act_in = '1;
        wgt_in = '1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk(busy == 1'b0, "R6 idle beats leave engine idle", int'(busy), 0);
        run_layer(2'b01, 4, 11, 1'b0, 1'b0, 0, "after idle beats R6");

        // R5: configuration during a running layer is refused.
        run_layer(2'b00, 6, 12, 1'b0, 1'b1, 0, "cfg while busy R5");
        run_layer(2'b10, 6, 13, 1'b1, 1'b1, 0, "cfg while busy gapped R5");

        // R6: beats past the count are ignored; zero-length layer.
        run_layer(2'b01, 5, 14, 1'b0, 1'b0, 6, "extra beats R6");
        run_layer(2'b00, 0, 15, 1'b0, 1'b0, 3, "zero length R6");

        // R3: largest sum, all-ones operands over the maximum beat count.
        run_layer(2'b00, (1 << LEN_W) - 1, 255, 1'b0, 1'b0, 0, "max sum R3");
        run_layer(2'b11, 2, 255, 1'b0, 1'b0, 0, "code 11 ones R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=0 exp=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule